// File: doc/BRIEF.md
# DMA Strobe Timing Generator

This block paces the read/write strobe of a DMA data transfer to an ATA device. When a transfer opens, it works out the cycle time the transfer needs. That cycle time depends on the requested transfer mode and on the minimum cycle time the device reports. The block then picks one of four fixed timing types and keeps that type until the transfer closes. The four types are A, B, C and D, from slowest to fastest. Each type has its own active and recovery length.

While the transfer is open, each accepted word request produces one strobe pulse. The strobe is high for the type's active ticks and then low for its recovery ticks. A one-cycle completion pulse follows the last recovery tick. One clock cycle is one timing tick, 62.5 ns at the default setting. Address generation and scatter-gather handling belong to other blocks.

Top module: `dma_strobe_gen`

## Requirements
- R1: After a synchronous active-low reset, `strobe`, `word_done`, `ready` and `xfer_open` are all 0.
- R2: The required cycle time is set by the mode code. Codes 0x21 and 0x22 (multiword modes 1 and 2) need max(250 ns, `dev_min_ns`). Codes 0x20 (multiword 0) and 0x10 to 0x12 (single-word 0 to 2) need 480 ns. Any code above 0x22 is treated as 0x22.
- R3: When `mode_ok` is low, or the code is not one of those listed in R2 and not above 0x22, the required cycle time falls back to 480 ns.
- R4: The chosen type is the fastest type whose full cycle is at least the required time. The full cycles are D = 187 ns (3 ticks), C = 250 ns (4 ticks), B = 437 ns (7 ticks) and A = 562 ns (9 ticks). A requirement above 562 ns selects A. The type is reported on `xfer_type` with A=0, B=1, C=2 and D=3.
- R5: An accepted request drives `strobe` high starting in the next cycle. It stays high for the active ticks (A 4, B 3, C 2, D 1) and then low for the recovery ticks (A 5, B 4, C 2, D 2). Requests held high back to back therefore repeat every active+recovery ticks.
- R6: `ready` is high while the transfer is open and either no word is in progress or the last recovery tick is under way. A request made while `ready` is low is ignored.
- R7: `word_done` pulses high for exactly one cycle, in the cycle after each word's last recovery tick.
- R8: A start pulse while no transfer is open latches the chosen type and opens the transfer. A start pulse while a transfer is open is ignored, and `xfer_type` does not change even if the mode inputs change.
- R9: A stop pulse while `ready` is high closes the transfer and takes priority over a request in the same cycle. A stop pulse at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock (one cycle = one timing tick) |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Open a transfer and latch the timing type |
| xfer_stop | input | 1 | Close the open transfer when idle between words |
| word_req | input | 1 | Request one strobe cycle |
| mode_code | input | 8 | Requested transfer mode code |
| dev_min_ns | input | NS_W | Device-reported minimum cycle time in ns |
| mode_ok | input | 1 | The mode was configured successfully on the device |
| strobe | output | 1 | Read/write strobe to the device |
| word_done | output | 1 | One-cycle pulse after each completed word |
| ready | output | 1 | A request would be accepted this cycle |
| xfer_open | output | 1 | A transfer is open |
| xfer_type | output | 2 | Latched timing type (A=0, B=1, C=2, D=3) |

## Verification
The bench opens transfers under several stimulus patterns:
- Fast multiword codes with device minimums of zero, 300 ns and 600 ns. These show whether the device minimum raises the cycle and whether the result lands on C, B or A.
- The slow multiword code, a single-word code and a code above the top mode. These separate the fixed 480 ns rule from the clamp.
- An unknown code, and a failed configuration. These check the fallback.

Words are issued singly, held back to back, and requested during active and recovery phases. This shows that the active and recovery lengths are exact, that no request is taken early, and that stop and start are honoured only at the allowed points.

// File: rtl/dsg_pkg.sv
// Package: shared types, mode codes and fixed tick counts of the four
// timing types. Assumes one clock cycle equals one timing tick.
package dsg_pkg;

    typedef enum logic [1:0] {
        TYP_A = 2'd0,
        TYP_B = 2'd1,
        TYP_C = 2'd2,
        TYP_D = 2'd3
    } tmg_type_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READY = 2'd1,
        PH_ACT   = 2'd2,
        PH_REC   = 2'd3
    } phase_e;

    localparam int NUM_TYPES = 4;
    localparam int MODE_W    = 8;

    localparam logic [MODE_W-1:0] MODE_SW0 = 8'h10;
    localparam logic [MODE_W-1:0] MODE_SW1 = 8'h11;
    localparam logic [MODE_W-1:0] MODE_SW2 = 8'h12;
    localparam logic [MODE_W-1:0] MODE_MW0 = 8'h20;
    localparam logic [MODE_W-1:0] MODE_MW1 = 8'h21;
    localparam logic [MODE_W-1:0] MODE_MW2 = 8'h22;

    // Active (strobe high) ticks of each timing type.
    function automatic int act_ticks(input logic [1:0] t);
        case (t)
            2'd0:    return 4;
            2'd1:    return 3;
            2'd2:    return 2;
            default: return 1;
        endcase
    endfunction

    // Recovery (strobe low) ticks of each timing type.
    function automatic int rec_ticks(input logic [1:0] t);
        case (t)
            2'd0:    return 5;
            2'd1:    return 4;
            default: return 2;
        endcase
    endfunction

    localparam int MAX_ACT   = 4;
    localparam int MAX_PHASE = 5;

endpackage

// File: rtl/dsg_cycle_sel.sv
// Module: dsg_cycle_sel
// Purpose: turns a mode code and a device minimum cycle into a required
// cycle time, then picks the fastest timing type that covers it.
// Assumes the types are ordered slowest (index 0) to fastest (index 3),
// so the last covering type in index order is the fastest one.
module dsg_cycle_sel
    import dsg_pkg::*;
#(
    parameter int NS_W        = 16,
    parameter int TICK_PS     = 62500,
    parameter int FAST_CYC_NS = 250,
    parameter int SLOW_CYC_NS = 480
) (
    input  logic [MODE_W-1:0] mode_code,
    input  logic [NS_W-1:0]   dev_min_ns,
    input  logic              mode_ok,
    output tmg_type_e         sel_type
);

    logic [MODE_W-1:0]    eff_mode;
    logic [NS_W-1:0]      need_ns;
    logic [NUM_TYPES-1:0] fits;

    // Clamp the mode and derive the required cycle time in ns.
    always_comb begin
        eff_mode = (mode_code > MODE_MW2) ? MODE_MW2 : mode_code;
        need_ns  = NS_W'(SLOW_CYC_NS);
        if (mode_ok) begin
            case (eff_mode)
                MODE_MW1, MODE_MW2:
                    need_ns = (dev_min_ns > NS_W'(FAST_CYC_NS)) ?
                              dev_min_ns : NS_W'(FAST_CYC_NS);
                MODE_MW0, MODE_SW0, MODE_SW1, MODE_SW2:
                    need_ns = NS_W'(SLOW_CYC_NS);
                default:
                    need_ns = NS_W'(SLOW_CYC_NS);
            endcase
        end
    end

    // One comparator per timing type against its full cycle in ns.
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_fit
        localparam int CYC_NS =
            (act_ticks(2'(t)) + rec_ticks(2'(t))) * TICK_PS / 1000;
        assign fits[t] = (need_ns <= NS_W'(CYC_NS));
    end

    // Keep the fastest covering type; type A when none covers.
    always_comb begin
        sel_type = TYP_A;
        for (int t = 0; t < NUM_TYPES; t++) begin
            if (fits[t]) sel_type = tmg_type_e'(2'(t));
        end
    end

endmodule

// File: rtl/dsg_strobe_seq.sv
// Module: dsg_strobe_seq
// Purpose: per-transfer sequencer. It latches the timing type at start and
// runs one active phase and one recovery phase per accepted request.
// Assumes the start, stop and request inputs are synchronous pulses or levels.
module dsg_strobe_seq
    import dsg_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      xfer_start,
    input  logic      xfer_stop,
    input  logic      word_req,
    input  tmg_type_e sel_type,
    output logic      strobe,
    output logic      word_done,
    output logic      ready,
    output logic      xfer_open,
    output tmg_type_e xfer_type
);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             last_rec;

    // Decode the phase into the outward status.
    always_comb begin
        last_rec  = (phase == PH_REC) && (cnt == '0);
        ready     = (phase == PH_READY) || last_rec;
        strobe    = (phase == PH_ACT);
        xfer_open = (phase != PH_IDLE);
    end

    // Advance the phase, the tick counter, the latched type and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            xfer_type <= TYP_A;
            word_done <= 1'b0;
        end else begin
            word_done <= last_rec;
            if (phase == PH_IDLE) begin
                if (xfer_start) begin
                    xfer_type <= sel_type;
                    phase     <= PH_READY;
                end
            end else if (ready) begin
                if (xfer_stop) begin
                    phase <= PH_IDLE;
                end else if (word_req) begin
                    phase <= PH_ACT;
                    cnt   <= CNT_W'(act_ticks(xfer_type) - 1);
                end else begin
                    phase <= PH_READY;
                end
            end else if (phase == PH_ACT) begin
                if (cnt == '0) begin
                    phase <= PH_REC;
                    cnt   <= CNT_W'(rec_ticks(xfer_type) - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_strobe_gen.sv
// Module: dma_strobe_gen (top)
// Purpose: DMA strobe timing generator. It chooses one of four timing
// types from the mode and the device minimum cycle, then paces one strobe
// per word request. Assumes the clock period equals TICK_PS.
module dma_strobe_gen
    import dsg_pkg::*;
#(
    parameter int NS_W        = 16,
    parameter int TICK_PS     = 62500,
    parameter int FAST_CYC_NS = 250,
    parameter int SLOW_CYC_NS = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              word_req,
    input  logic [7:0]        mode_code,
    input  logic [NS_W-1:0]   dev_min_ns,
    input  logic              mode_ok,
    output logic              strobe,
    output logic              word_done,
    output logic              ready,
    output logic              xfer_open,
    output logic [1:0]        xfer_type
);

    localparam int CNT_W = $clog2(MAX_PHASE + 1);

    tmg_type_e sel_type;
    tmg_type_e cur_type;

    dsg_cycle_sel #(
        .NS_W        (NS_W),
        .TICK_PS     (TICK_PS),
        .FAST_CYC_NS (FAST_CYC_NS),
        .SLOW_CYC_NS (SLOW_CYC_NS)
    ) u_sel (
        .mode_code  (mode_code),
        .dev_min_ns (dev_min_ns),
        .mode_ok    (mode_ok),
        .sel_type   (sel_type)
    );

    dsg_strobe_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_stop  (xfer_stop),
        .word_req   (word_req),
        .sel_type   (sel_type),
        .strobe     (strobe),
        .word_done  (word_done),
        .ready      (ready),
        .xfer_open  (xfer_open),
        .xfer_type  (cur_type)
    );

    assign xfer_type = cur_type;

endmodule

// File: rtl/dma_strobe_gen_chk.sv
// Module: dma_strobe_gen_chk
// Purpose: protocol checks on the top-level ports, attached by bind.
module dma_strobe_gen_chk
    import dsg_pkg::*;
#(
    parameter int NS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            xfer_start,
    input logic            xfer_stop,
    input logic            word_req,
    input logic [7:0]      mode_code,
    input logic [NS_W-1:0] dev_min_ns,
    input logic            mode_ok,
    input logic            strobe,
    input logic            word_done,
    input logic            ready,
    input logic            xfer_open,
    input logic [1:0]      xfer_type
);

    logic [3:0] run_q;

    // Count how many cycles in a row the strobe has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (strobe) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!strobe && !word_done && !xfer_open));

    assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (run_q < 4'(MAX_ACT)));

    assert_strobe_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> xfer_open);

    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(ready && word_req && !xfer_stop));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    assert_type_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_open && $past(xfer_open)) |-> $stable(xfer_type));

    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && xfer_stop) |=> !xfer_open);

endmodule

bind dma_strobe_gen dma_strobe_gen_chk #(.NS_W(NS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_stop  (xfer_stop),
    .word_req   (word_req),
    .mode_code  (mode_code),
    .dev_min_ns (dev_min_ns),
    .mode_ok    (mode_ok),
    .strobe     (strobe),
    .word_done  (word_done),
    .ready      (ready),
    .xfer_open  (xfer_open),
    .xfer_type  (xfer_type)
);

// File: tb/tb_dma_strobe_gen.sv
// Bench: behavioural reference model compared with the outputs every cycle,
// plus directed checks on type selection and strobe lengths.
module tb_dma_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_stop = 1'b0;
    logic        word_req = 1'b0;
    logic [7:0]  mode_code = 8'h22;
    logic [15:0] dev_min_ns = 16'd0;
    logic        mode_ok = 1'b1;
    logic        strobe, word_done, ready, xfer_open;
    logic [1:0]  xfer_type;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .word_req(word_req), .mode_code(mode_code), .dev_min_ns(dev_min_ns),
        .mode_ok(mode_ok), .strobe(strobe), .word_done(word_done), .ready(ready),
        .xfer_open(xfer_open), .xfer_type(xfer_type)
    );

    // Expected type from the cycle-time and selection rules (R2, R3, R4).
    function automatic int exp_type(int mode, int dev, bit ok);
        int m, need;
        m = (mode > 'h22) ? 'h22 : mode;
        if (!ok) need = 480;
        else if (m == 'h21 || m == 'h22) need = (dev > 250) ? dev : 250;
        else need = 480;
        if (need <= 187) return 3;
        if (need <= 250) return 2;
        if (need <= 437) return 1;
        return 0;
    endfunction

    function automatic int act_of(int t);
        int tbl[4] = '{4, 3, 2, 1};
        return tbl[t];
    endfunction

    function automatic int rec_of(int t);
        int tbl[4] = '{5, 4, 2, 2};
        return tbl[t];
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state: phase 0 ready, 1 active, 2 recovery.
    bit m_open = 0;
    int m_ph = 0;
    int m_left = 0;
    int m_type = 0;
    bit m_done = 0;

    function automatic bit m_ready();
        return m_open && (m_ph == 0 || (m_ph == 2 && m_left == 1));
    endfunction

    // Advance the model on each rising edge from the inputs held at that edge.
    always @(posedge clk) begin : model
        bit rdy, nd;
        rdy = m_ready();
        nd  = m_open && m_ph == 2 && m_left == 1;
        if (!rst_n) begin
            m_open = 0; m_ph = 0; m_left = 0; m_type = 0; nd = 0;
        end else if (!m_open) begin
            if (xfer_start) begin
                m_open = 1; m_ph = 0;
                m_type = exp_type(mode_code, dev_min_ns, mode_ok);
            end
        end else if (rdy) begin
            if (xfer_stop) begin m_open = 0; m_ph = 0; end
            else if (word_req) begin m_ph = 1; m_left = act_of(m_type); end
            else m_ph = 0;
        end else if (m_ph == 1) begin
            if (m_left == 1) begin m_ph = 2; m_left = rec_of(m_type); end
            else m_left--;
        end else begin
            m_left--;
        end
        m_done = nd;
    end

    // Compare every output with the model at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(strobe === (m_open && m_ph == 1), "R5 strobe", strobe, m_open && m_ph == 1);
            chk(ready === m_ready(), "R6 ready", ready, m_ready());
            chk(word_done === m_done, "R7 word_done", word_done, m_done);
            chk(xfer_open === m_open, "R9 xfer_open", xfer_open, m_open);
            chk(xfer_type === 2'(m_type), "R8 xfer_type", xfer_type, m_type);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic open_xfer(int mode, int dev, bit ok);
        mode_code = 8'(mode); dev_min_ns = 16'(dev); mode_ok = ok;
        xfer_start = 1; tick(1); xfer_start = 0; tick(1);
    endtask

    task automatic close_xfer();
        while (!ready) tick(1);
        xfer_stop = 1; tick(1); xfer_stop = 0; tick(1);
    endtask

    task automatic one_word();
        while (!ready) tick(1);
        word_req = 1; tick(1); word_req = 0; tick(12);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(4 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int hi;
        tick(3);
        chk(!strobe && !word_done && !ready && !xfer_open, "R1 reset outputs",
            {strobe, word_done, ready, xfer_open}, 0);
        rst_n = 1; tick(1);

        // R2: multiword 2 with a low device minimum gives type C.
        open_xfer('h22, 0, 1);
        chk(xfer_type == 2'd2, "R2 mw2 type", xfer_type, 2);
        one_word();
        word_req = 1; tick(14); word_req = 0; tick(6);
        close_xfer();

        // R2: multiword 1 with a 300 ns device minimum gives type B.
        open_xfer('h21, 300, 1);
        chk(xfer_type == 2'd1, "R2 dev min type", xfer_type, 1);
        one_word();
        close_xfer();

        // R4: a device minimum above 562 ns gives type A.
        open_xfer('h22, 600, 1);
        chk(xfer_type == 2'd0, "R4 large need type", xfer_type, 0);
        close_xfer();

        // R2: multiword 0 gives type A; count strobe-high cycles (R5).
        open_xfer('h20, 0, 1);
        chk(xfer_type == 2'd0, "R2 mw0 type", xfer_type, 0);
        word_req = 1; tick(1); word_req = 0;
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            if (strobe) hi++;
            tick(1);
        end
        chk(hi == 4, "R5 type A active ticks", hi, 4);
        close_xfer();

        // R2: a single-word code gives type A; a clamped code gives type C.
        open_xfer('h11, 0, 1);
        chk(xfer_type == 2'd0, "R2 sw1 type", xfer_type, 0);
        close_xfer();
        open_xfer('h45, 0, 1);
        chk(xfer_type == 2'd2, "R2 clamp type", xfer_type, 2);
        one_word();
        close_xfer();

        // R3: an unknown code and a failed configuration both fall back.
        open_xfer('h05, 0, 1);
        chk(xfer_type == 2'd0, "R3 unknown code", xfer_type, 0);
        close_xfer();
        open_xfer('h22, 0, 0);
        chk(xfer_type == 2'd0, "R3 config failed", xfer_type, 0);

        // R8: start while open is ignored even with new mode inputs.
        mode_code = 8'h22; mode_ok = 1;
        xfer_start = 1; tick(1); xfer_start = 0; tick(1);
        chk(xfer_type == 2'd0, "R8 restart ignored", xfer_type, 0);

        // R6/R9: request and stop mid-word are ignored.
        word_req = 1; tick(1); word_req = 0; tick(1);
        word_req = 1; xfer_stop = 1; tick(1); word_req = 0; xfer_stop = 0;
        chk(xfer_open == 1'b1, "R9 stop mid-word ignored", xfer_open, 1);
        tick(10);

        // R9: stop beats a request when ready.
        word_req = 1; xfer_stop = 1; tick(1); word_req = 0; xfer_stop = 0;
        chk(xfer_open == 1'b0 && strobe == 1'b0, "R9 stop wins",
            {xfer_open, strobe}, 0);
        tick(4);
        finish_run();
    end

endmodule